// File: doc/BRIEF.md
# SPI Paged Register Slave

This block is the device end of a byte-oriented SPI register protocol. A master opens a frame by pulling chip select low, sends a control byte that names the direction, then an 8-bit offset inside the page that is currently selected. Writes carry their data in the same frame. Reads are split into two steps. Reading an ordinary offset only arms an internal fetch. The master then polls a status byte and, once the fetch has landed, reads the fetched value out of a buffer window.

On the inside the block drives a simple request/acknowledge register port. The port carries the page, the offset, the width in bytes and the write data, and it returns a full-width read value. The block holds the current page number, a busy flag, a read-ready flag and the buffer. The SPI pins are sampled with the system clock, which must run at least four times faster than the serial clock.

Top module: `spi_paged_regs`

## Requirements
- R1: After reset, page is 0, busy and read-ready are clear, a status read returns 0x00, and `bus_req` is low.
- R2: A write frame (control 0x61) to offset 0xFF stores its first data byte as the page that later bus accesses carry on `bus_page`. No bus transaction is issued for this frame.
- R3: A write frame to any other offset with 1, 2, 4, 6 or 8 data bytes issues one bus write when chip select rises. The write carries the current page, the offset and `bus_width` equal to the byte count. The first data byte sits in `bus_wdata[7:0]`, each next byte sits 8 bits higher, and the unused upper bytes are zero.
- R4: A write frame with 0, 3, 5, 7 or more than 8 data bytes issues no bus transaction.
- R5: A read frame (control 0x60) of an offset other than 0xF0 and 0xFE issues a bus read of the current page and that offset with `bus_width` = 8. Status bit 7 (busy) stays set until `bus_ack`.
- R6: When a bus read is acknowledged, status bit 5 (read-ready) sets. A read frame of offset 0xF0 then returns the fetched value least significant byte first in the bytes after the offset, and returns 0x00 beyond the eighth byte.
- R7: Read-ready clears when a read of an ordinary offset arrives. It also clears when a frame that read at least one byte from offset 0xF0 ends.
- R8: A read of offset 0xFE returns {busy, 0, read-ready, 5'b0} in every byte after the offset, and it changes neither flag.
- R9: A frame whose control byte is neither 0x60 nor 0x61 is ignored until chip select rises. It issues no bus access, leaves the page unchanged and drives MISO low.
- R10: A write or fetch requested while busy is set is dropped.
- R11: While `bus_req` is high and not yet acknowledged, `bus_req`, `bus_we`, `bus_page`, `bus_offset`, `bus_width` and `bus_wdata` hold steady.
- R12: SPI uses mode 0. The slave samples MOSI on the rising edge of SCK and updates MISO after it, most significant bit first in each byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Chip select, active low, frames a transfer |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, low outside a frame |
| bus_req | output | 1 | Register port request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_page | output | 8 | Page of the access |
| bus_offset | output | 8 | Offset of the access within the page |
| bus_width | output | 4 | Access width in bytes |
| bus_wdata | output | 64 | Write data, first received byte in the low bits |
| bus_ack | input | 1 | One-cycle completion of the current request |
| bus_rdata | input | 64 | Read data, valid with `bus_ack` on a read |

## Verification
A wrong page register shows on the first bus transaction after the corrupting frame, in `bus_page`. A corrupted byte counter or write-data assembly shows the moment chip select rises, as a wrong `bus_width`, a misplaced byte in `bus_wdata`, or a transaction that should not exist. Flag errors reach the pins through the next status poll. A read-ready bit left stale, or cleared too early, shows in the very next 0xFE frame. Buffer-order or bit-order faults show in the first 0xF0 readback, byte by byte, against values that the bench computes from the page and offset it asked for.

// File: rtl/spi_regs_pkg.sv
// Package: shared constants and frame state type for the SPI paged register slave.
package spi_regs_pkg;

    localparam logic [7:0] CTRL_READ  = 8'h60;
    localparam logic [7:0] CTRL_WRITE = 8'h61;
    localparam logic [7:0] OFS_PAGE   = 8'hFF;
    localparam logic [7:0] OFS_STATUS = 8'hFE;
    localparam logic [7:0] OFS_BUFFER = 8'hF0;
    localparam int         STAT_BUSY  = 7;
    localparam int         STAT_READY = 5;

    typedef enum logic [1:0] {
        FR_CTRL,   // waiting for the control byte
        FR_OFFS,   // waiting for the offset byte
        FR_BODY,   // data bytes in or out
        FR_SKIP    // rejected control byte, ignore until deselect
    } frame_st_t;

endpackage

// File: rtl/spi_byte_link.sv
// Module: spi_byte_link
// Brings SCK, CS_N and MOSI into the system clock domain, assembles received
// bytes (mode 0, MSB first) and presents the outgoing byte bit by bit on MISO.
// Assumes clk is at least 4x the SCK rate; tx_byte must settle within the
// half SCK period that follows a byte boundary.
module spi_byte_link #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    output logic       miso,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       frame_end
);

    logic [SYNC_STAGES:0]   sck_sr;
    logic [SYNC_STAGES:0]   cs_sr;
    logic [SYNC_STAGES-1:0] mosi_sr;
    logic                   sck_rise;
    logic                   active;
    logic [2:0]             bit_cnt;
    logic [6:0]             shreg;

    // Synchronizer chains; the extra stage on SCK/CS gives edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_sr  <= '0;
            cs_sr   <= '1;
            mosi_sr <= '0;
        end else begin
            sck_sr  <= {sck_sr[SYNC_STAGES-1:0], sck};
            cs_sr   <= {cs_sr[SYNC_STAGES-1:0], cs_n};
            mosi_sr <= {mosi_sr[SYNC_STAGES-2:0], mosi};
        end
    end

    assign sck_rise  = sck_sr[SYNC_STAGES-1] & ~sck_sr[SYNC_STAGES];
    assign active    = ~cs_sr[SYNC_STAGES-1];
    assign frame_end = cs_sr[SYNC_STAGES-1] & ~cs_sr[SYNC_STAGES];

    // Shift in MOSI on each SCK rise and flag every completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (!active) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                shreg   <= {shreg[5:0], mosi_sr[SYNC_STAGES-1]};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    rx_valid <= 1'b1;
                    rx_byte  <= {shreg, mosi_sr[SYNC_STAGES-1]};
                end
            end
        end
    end

    // MISO shows the bit the master samples on its next rising edge.
    assign miso = active & tx_byte[3'd7 - bit_cnt];

endmodule

// File: rtl/spi_frame_ctrl.sv
// Module: spi_frame_ctrl
// Decodes control/offset bytes of each frame, gathers write data, raises
// one-cycle commands (page store, bus write, fetch, buffer drained) and picks
// the byte returned to the master. Assumes bytes arrive via rx_valid pulses.
module spi_frame_ctrl
    import spi_regs_pkg::*;
#(
    parameter int  MAX_BYTES = 8,
    localparam int DATA_W    = 8 * MAX_BYTES,
    localparam int CNT_W     = $clog2(MAX_BYTES + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              frame_end,
    input  logic [7:0]        status_byte,
    input  logic [DATA_W-1:0] buf_data,
    output logic [7:0]        tx_byte,
    output logic              page_we,
    output logic [7:0]        page_val,
    output logic              wr_go,
    output logic              rd_go,
    output logic              drained,
    output logic [7:0]        req_offset,
    output logic [CNT_W-1:0]  wr_count,
    output logic [DATA_W-1:0] wr_data
);

    frame_st_t         st;
    logic              is_write;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] buf_sh;

    // True for the byte counts a write may legally carry (1 or even up to max).
    function automatic logic width_ok(input logic [CNT_W-1:0] n);
        return (n == CNT_W'(1)) ||
               ((n[0] == 1'b0) && (n != '0) && (n <= CNT_W'(MAX_BYTES)));
    endfunction

    // Frame sequencing, byte counting and command generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= FR_CTRL;
            is_write   <= 1'b0;
            cnt        <= '0;
            req_offset <= '0;
            wr_data    <= '0;
            page_we    <= 1'b0;
            page_val   <= '0;
            wr_go      <= 1'b0;
            rd_go      <= 1'b0;
            drained    <= 1'b0;
        end else begin
            page_we <= 1'b0;
            wr_go   <= 1'b0;
            rd_go   <= 1'b0;
            drained <= 1'b0;
            if (frame_end) begin
                if (st == FR_BODY) begin
                    if (is_write && req_offset != OFS_PAGE && width_ok(cnt))
                        wr_go <= 1'b1;
                    if (!is_write && req_offset == OFS_BUFFER && cnt != '0)
                        drained <= 1'b1;
                end
                st <= FR_CTRL;
            end else if (rx_valid) begin
                unique case (st)
                    FR_CTRL: begin
                        if (rx_byte == CTRL_READ) begin
                            is_write <= 1'b0;
                            st       <= FR_OFFS;
                        end else if (rx_byte == CTRL_WRITE) begin
                            is_write <= 1'b1;
                            st       <= FR_OFFS;
                        end else begin
                            st <= FR_SKIP;
                        end
                    end
                    FR_OFFS: begin
                        req_offset <= rx_byte;
                        cnt        <= '0;
                        wr_data    <= '0;
                        st         <= FR_BODY;
                        if (!is_write && rx_byte != OFS_STATUS && rx_byte != OFS_BUFFER)
                            rd_go <= 1'b1;
                    end
                    FR_BODY: begin
                        if (cnt <= CNT_W'(MAX_BYTES))
                            cnt <= cnt + CNT_W'(1);
                        if (is_write && cnt < CNT_W'(MAX_BYTES))
                            wr_data[{cnt, 3'b000} +: 8] <= rx_byte;
                        if (is_write && req_offset == OFS_PAGE && cnt == '0) begin
                            page_we  <= 1'b1;
                            page_val <= rx_byte;
                        end
                    end
                    default: st <= FR_SKIP;
                endcase
            end
        end
    end

    assign wr_count = cnt;
    assign buf_sh   = buf_data >> {cnt, 3'b000};

    // Byte sent to the master: status, buffer window, or zero.
    always_comb begin
        tx_byte = 8'h00;
        if (st == FR_BODY && !is_write) begin
            if (req_offset == OFS_STATUS)
                tx_byte = status_byte;
            else if (req_offset == OFS_BUFFER)
                tx_byte = buf_sh[7:0];
        end
    end

endmodule

// File: rtl/spi_paged_regs.sv
// Module: spi_paged_regs (top)
// SPI slave exposing a paged register space on a request/acknowledge port.
// Holds the page number, busy and read-ready flags and the fetch buffer.
// Assumes bus_ack is a one-cycle pulse while bus_req is high.
module spi_paged_regs
    import spi_regs_pkg::*;
#(
    parameter int  MAX_BYTES   = 8,
    parameter int  SYNC_STAGES = 2,
    localparam int DATA_W      = 8 * MAX_BYTES,
    localparam int WID_W       = $clog2(MAX_BYTES + 1),
    localparam int CNT_W       = $clog2(MAX_BYTES + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              bus_req,
    output logic              bus_we,
    output logic [7:0]        bus_page,
    output logic [7:0]        bus_offset,
    output logic [WID_W-1:0]  bus_width,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);

    logic              rx_valid;
    logic [7:0]        rx_byte;
    logic              frame_end;
    logic [7:0]        tx_byte;
    logic              page_we;
    logic [7:0]        page_val;
    logic              wr_go;
    logic              rd_go;
    logic              drained;
    logic [7:0]        req_offset;
    logic [CNT_W-1:0]  wr_count;
    logic [DATA_W-1:0] wr_data;
    logic [7:0]        page_q;
    logic              busy_q;
    logic              rack_q;
    logic [DATA_W-1:0] buf_q;
    logic [7:0]        status_byte;

    spi_byte_link #(.SYNC_STAGES(SYNC_STAGES)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck       (spi_sck),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .tx_byte   (tx_byte),
        .miso      (spi_miso),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .frame_end (frame_end)
    );

    spi_frame_ctrl #(.MAX_BYTES(MAX_BYTES)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .frame_end   (frame_end),
        .status_byte (status_byte),
        .buf_data    (buf_q),
        .tx_byte     (tx_byte),
        .page_we     (page_we),
        .page_val    (page_val),
        .wr_go       (wr_go),
        .rd_go       (rd_go),
        .drained     (drained),
        .req_offset  (req_offset),
        .wr_count    (wr_count),
        .wr_data     (wr_data)
    );

    always_comb begin
        status_byte             = 8'h00;
        status_byte[STAT_BUSY]  = busy_q;
        status_byte[STAT_READY] = rack_q;
    end

    // Page register, updated by writes to the page-select offset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_q <= '0;
        else if (page_we)
            page_q <= page_val;
    end

    // Bus request launch/completion, flags and fetch buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            rack_q     <= 1'b0;
            buf_q      <= '0;
            bus_we     <= 1'b0;
            bus_page   <= '0;
            bus_offset <= '0;
            bus_width  <= '0;
            bus_wdata  <= '0;
        end else begin
            if (drained || rd_go)
                rack_q <= 1'b0;
            if (busy_q) begin
                if (bus_ack) begin
                    busy_q <= 1'b0;
                    if (!bus_we) begin
                        buf_q  <= bus_rdata;
                        rack_q <= 1'b1;
                    end
                end
            end else if (wr_go) begin
                busy_q     <= 1'b1;
                bus_we     <= 1'b1;
                bus_page   <= page_q;
                bus_offset <= req_offset;
                bus_width  <= WID_W'(wr_count);
                bus_wdata  <= wr_data;
            end else if (rd_go) begin
                busy_q     <= 1'b1;
                bus_we     <= 1'b0;
                bus_page   <= page_q;
                bus_offset <= req_offset;
                bus_width  <= WID_W'(MAX_BYTES);
                bus_wdata  <= '0;
            end
        end
    end

    assign bus_req = busy_q;

endmodule

// File: rtl/spi_paged_regs_chk.sv
// Module: spi_paged_regs_chk
// Protocol checks on the register port and read-ready flag, bound into the top.
module spi_paged_regs_chk #(
    parameter int  MAX_BYTES = 8,
    localparam int DATA_W    = 8 * MAX_BYTES,
    localparam int WID_W     = $clog2(MAX_BYTES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [7:0]        bus_page,
    input logic [7:0]        bus_offset,
    input logic [WID_W-1:0]  bus_width,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ack,
    input logic              rack
);

    logic legal_w;
    assign legal_w = (bus_width == WID_W'(1)) ||
                     (bus_width[0] == 1'b0 && bus_width != '0 &&
                      bus_width <= WID_W'(MAX_BYTES));

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_page) &&
        $stable(bus_offset) && $stable(bus_width) && $stable(bus_wdata));

    assert_write_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we |-> legal_w);

    assert_write_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we |-> (bus_wdata >> {bus_width, 3'b000}) == '0);

    assert_fetch_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_we |-> bus_width == WID_W'(MAX_BYTES));

    assert_ready_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack && !bus_we |=> rack);

    assert_ready_low_in_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_we |-> !rack);

endmodule

bind spi_paged_regs spi_paged_regs_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_page   (bus_page),
    .bus_offset (bus_offset),
    .bus_width  (bus_width),
    .bus_wdata  (bus_wdata),
    .bus_ack    (bus_ack),
    .rack       (rack_q)
);

// File: tb/spi_paged_regs_tb.sv
`timescale 1ns/1ps
// Bench: SPI master tasks, register-port responder, seeded random plus directed cases.
module spi_paged_regs_tb;

    localparam int HALF = 8;   // clk cycles per SCK half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sck = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        bus_req;
    logic        bus_we;
    logic [7:0]  bus_page;
    logic [7:0]  bus_offset;
    logic [3:0]  bus_width;
    logic [63:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [63:0] bus_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] txq [16];
    logic [7:0] rxq [16];

    bit          hold = 1'b0;
    int          ack_cnt = 0;
    logic        l_we;
    logic [7:0]  l_page, l_off;
    logic [3:0]  l_w;
    logic [63:0] l_data;

    always #4 clk = ~clk;   // 125 MHz

    spi_paged_regs u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .bus_req(bus_req),
        .bus_we(bus_we), .bus_page(bus_page), .bus_offset(bus_offset),
        .bus_width(bus_width), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata)
    );

    // Value the register space returns for a page/offset pair.
    function automatic logic [63:0] model_rd(input logic [7:0] p, input logic [7:0] o);
        return {p, o, ~p, ~o, p + o, p ^ 8'h5A, o ^ 8'hA5, 8'h3C};
    endfunction

    assign bus_rdata = model_rd(bus_page, bus_offset);

    function automatic logic [7:0] status_of(input bit busy, input bit rdy);
        return {busy, 1'b0, rdy, 5'b0};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Register port responder: acks after a short delay unless held.
    initial begin
        int dly = 0;
        forever begin
            @(negedge clk);
            if (bus_ack) bus_ack = 1'b0;
            else if (bus_req && !hold) begin
                if (dly >= 3) begin
                    bus_ack = 1'b1;
                    dly = 0;
                    ack_cnt++;
                    l_we = bus_we; l_page = bus_page; l_off = bus_offset;
                    l_w = bus_width; l_data = bus_wdata;
                end else dly++;
            end
        end
    end

    // One SPI mode-0 frame of n bytes from txq, captured bytes into rxq.
    task automatic frame(input int n);
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            for (int b = 7; b >= 0; b--) begin
                spi_mosi = txq[i][b];
                repeat (HALF) @(negedge clk);
                rxq[i][b] = spi_miso;
                spi_sck = 1'b1;
                repeat (HALF) @(negedge clk);
                spi_sck = 1'b0;
            end
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && bus_req; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic get_status(output logic [7:0] s);
        txq[0] = 8'h60; txq[1] = 8'hFE; txq[2] = 8'h00;
        frame(3);
        s = rxq[2];
    endtask

    task automatic wr_frame(input logic [7:0] off, input logic [63:0] d, input int nb);
        txq[0] = 8'h61; txq[1] = off;
        for (int i = 0; i < nb; i++) txq[2 + i] = (i < 8) ? d[8*i +: 8] : 8'hEE;
        frame(2 + nb);
    endtask

    task automatic rd_arm(input logic [7:0] off);
        txq[0] = 8'h60; txq[1] = off; txq[2] = 8'h00;
        frame(3);
    endtask

    // Read 10 buffer bytes and compare with the model value.
    task automatic readback(input logic [63:0] exp, input string tag);
        logic [63:0] got = '0;
        bit ok = 1'b1;
        txq[0] = 8'h60; txq[1] = 8'hF0;
        for (int i = 2; i < 12; i++) txq[i] = 8'h00;
        frame(12);
        for (int i = 0; i < 8; i++) got[8*i +: 8] = rxq[2 + i];
        if (rxq[10] != 8'h00 || rxq[11] != 8'h00) ok = 1'b0;
        check(ok && got == exp, tag, got, exp);
    endtask

    task automatic check_txn(input bit we, input logic [7:0] p, input logic [7:0] o,
                             input logic [3:0] w, input logic [63:0] d,
                             input int cnt0, input string tag);
        check(ack_cnt == cnt0 + 1, tag, 64'(ack_cnt - cnt0), 64'd1);
        check({l_we, l_page, l_off, l_w} == {we, p, o, w} && l_data == d, tag,
              {l_we, l_page, l_off, l_w}, {we, p, o, w});
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0]  s;
        logic [7:0]  page;
        logic [63:0] d;
        int          c0;
        int          ws [5] = '{1, 2, 4, 6, 8};
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state
        check(bus_req == 1'b0, "R1 bus_req", 64'(bus_req), 64'd0);
        get_status(s);
        check(s == 8'h00, "R1 status", 64'(s), 64'h00);
        c0 = ack_cnt;
        wr_frame(8'h10, 64'hA5, 1); wait_idle();
        check_txn(1'b1, 8'h00, 8'h10, 4'd1, 64'hA5, c0, "R1 page0");

        // R2 + R3: page select then 2-byte write, LSB first
        c0 = ack_cnt;
        wr_frame(8'hFF, 64'h07, 1); wait_idle();
        check(ack_cnt == c0, "R2 no txn", 64'(ack_cnt - c0), 64'd0);
        page = 8'h07;
        c0 = ack_cnt;
        wr_frame(8'h12, 64'hBEEF, 2); wait_idle();
        check_txn(1'b1, page, 8'h12, 4'd2, 64'hBEEF, c0, "R3 R2 write16");

        // R4: illegal counts
        foreach (ws[k]) begin end
        for (int k = 0; k < 5; k++) begin
            int bad [5] = '{0, 3, 5, 7, 9};
            c0 = ack_cnt;
            wr_frame(8'h20, 64'h1122334455667788, bad[k]); wait_idle();
            check(ack_cnt == c0, "R4 dropped count", 64'(bad[k]), 64'd0);
        end

        // R5 + R10: fetch held busy, write during busy dropped
        hold = 1'b1;
        c0 = ack_cnt;
        rd_arm(8'h34);
        get_status(s);
        check(s == status_of(1, 0), "R5 busy", 64'(s), 64'(status_of(1, 0)));
        check(bus_req && !bus_we && bus_width == 4'd8 && bus_page == page && bus_offset == 8'h34,
              "R5 fetch fields", {bus_we, bus_width, bus_page, bus_offset}, {1'b0, 4'd8, page, 8'h34});
        wr_frame(8'h40, 64'h99, 1);
        hold = 1'b0; wait_idle();
        repeat (40) @(negedge clk);
        check(ack_cnt == c0 + 1 && l_we == 1'b0, "R10 busy drop", 64'(ack_cnt - c0), 64'd1);

        // R6 + R8 + R12: ready flag, status stable, buffer readback
        get_status(s);
        check(s == status_of(0, 1), "R6 ready", 64'(s), 64'(status_of(0, 1)));
        get_status(s);
        check(s == status_of(0, 1), "R8 status no side effect", 64'(s), 64'(status_of(0, 1)));
        readback(model_rd(page, 8'h34), "R6 R12 buffer LSB first");
        // R7: ready clears after buffer read
        get_status(s);
        check(s == 8'h00, "R7 clear after drain", 64'(s), 64'h00);

        // R7: ready clears when a new ordinary read begins
        rd_arm(8'h35); wait_idle();
        hold = 1'b1;
        rd_arm(8'h36);
        get_status(s);
        check(s == status_of(1, 0), "R7 clear on new read", 64'(s), 64'(status_of(1, 0)));
        hold = 1'b0; wait_idle();
        readback(model_rd(page, 8'h36), "R6 second fetch");

        // R9: bad control byte ignored
        c0 = ack_cnt;
        txq[0] = 8'h55; txq[1] = 8'hFF; txq[2] = 8'h09; txq[3] = 8'h00;
        frame(4); wait_idle();
        check(ack_cnt == c0 && rxq[2] == 8'h00 && rxq[3] == 8'h00, "R9 ignored",
              64'(ack_cnt - c0), 64'd0);
        c0 = ack_cnt;
        wr_frame(8'h50, 64'h3, 1); wait_idle();
        check_txn(1'b1, page, 8'h50, 4'd1, 64'h3, c0, "R9 page kept");

        // Random mix
        for (int it = 0; it < 30; it++) begin
            int op = $urandom_range(0, 2);
            logic [7:0] off = 8'($urandom_range(0, 8'hEF));
            if (op == 0) begin
                page = 8'($urandom);
                wr_frame(8'hFF, 64'(page), 1); wait_idle();
            end else if (op == 1) begin
                int w = ws[$urandom_range(0, 4)];
                d = {$urandom, $urandom};
                d = (w == 8) ? d : (d & ((64'd1 << (8 * w)) - 1));
                c0 = ack_cnt;
                wr_frame(off, d, w); wait_idle();
                check_txn(1'b1, page, off, 4'(w), d, c0, "R3 random write");
            end else begin
                rd_arm(off); wait_idle();
                get_status(s);
                check(s == status_of(0, 1), "R6 random ready", 64'(s), 64'(status_of(0, 1)));
                readback(model_rd(page, off), "R6 R12 random readback");
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule